// File: doc/BRIEF.md
# Real-time clock timer

This block is a memory-mapped clock timer on a 4-bit peripheral data bus. While running, it counts a 256 Hz enable tick into an 8-bit value. Bit 0 of that value toggles at 128 Hz and bit 7 toggles at 1 Hz. Software reads the value as two read-only nibbles and controls the timer through a control register. That register has a start/stop bit and a self-clearing clear bit. Four interrupt factor flags record the rollover of the 32, 8, 2 and 1 Hz stages. Each flag has its own enable bit, and together they drive one interrupt request line.

The value is wider than the bus, so it is read in two accesses. Reading the low nibble captures a copy of the high nibble, and later reads of the high nibble return that copy. The copy is released when the high nibble is read. It is also released when `HOLD_TICKS` pulses of a 2 kHz timeout tick have arrived, which puts the release between 0.5 and 1.0 ms after the capture.

Two state machines form the core. The run machine has states `RUN_OFF` and `RUN_ON`. Its transition START is a control write with bit 0 set while stopped. Its transition HALT is a control write with bit 0 clear while running. The snapshot machine has states `SNAP_IDLE` and `SNAP_HELD`, and four transitions:
- CAPTURE: a low-nibble read in `SNAP_IDLE`, which takes the copy.
- RECAPTURE: a low-nibble read in `SNAP_HELD`, which takes a fresh copy and restarts the timeout.
- CONSUME: a high-nibble read in `SNAP_HELD`, which returns to idle.
- EXPIRE: the last timeout pulse in `SNAP_HELD`, which also returns to idle.

Top module: `rtc_clock_timer`

## Requirements
- R1: The control register is at address 0. Bit 0 is the run bit and reads back as written. Bit 1 is the clear command and always reads 0. Bits 3 and 2 read 0. Addresses 5 to 7 read 0.
- R2: A control write with bit 1 set clears the count in the next cycle. If bit 0 of the same write is 1, counting continues from zero on the next tick.
- R3: A clear while stopped leaves the count at zero through any number of ticks until the run bit is set.
- R4: While the run bit is 0, 256 Hz ticks leave the count unchanged. Setting the run bit resumes counting from the held value, one increment per tick.
- R5: Address 1 returns count bits 3..0, with D0 as the 128 Hz bit. Address 2 returns count bits 7..4, with D3 as the 1 Hz bit. Writes to either address have no effect. The count wraps from 0xFF to 0x00.
- R6: A read of address 1 captures the high nibble. Reads of address 2 return the captured value until address 2 has been read once, even if the count moves on. Another read of address 1 takes a new copy.
- R7: A capture is released after `HOLD_TICKS` timeout-tick pulses that arrive after it. With fewer pulses the copy is still returned.
- R8: Flags are at address 4: D0 is 32 Hz, D1 is 8 Hz, D2 is 2 Hz and D3 is 1 Hz. A flag is set when its count bit (2, 4, 6 or 7) falls on a tick while running.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it. If a set event and a clearing write fall in the same cycle, the flag ends up 1.
- R10: The enable register is at address 3, with the same bit order as the flags. `irq` is high exactly when some flag and its enable bit are both 1.
- R11: After reset, every register, flag and the count read 0, the timer is stopped and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_256 | input | 1 | One-cycle 256 Hz count enable |
| tick_hold | input | 1 | One-cycle 2 kHz pulse for the capture timeout |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (drives the capture logic) |
| wdata | input | 4 | Write data nibble |
| rdata | output | 4 | Read data nibble, valid in the cycle of `rd_en` |
| irq | output | 1 | Combined interrupt request |

## Verification
Two cases are hardest to reach from the ports. The first is a clearing write that lands in the same cycle as a stage rollover. The bench follows the count in its model, advances it to a value ending in 7 and then issues the flag write and the tick together. The second is showing that a capture survives one timeout pulse but not two. Any high-nibble read ends the capture, so the bench uses two separate captures: one is read after a single timeout pulse and the other after two. Between the capture and the read, the count has moved past a high-nibble boundary, so the held and live values differ.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned NIB_W  = 4;
    localparam int unsigned CNT_W  = 2 * NIB_W;
    localparam int unsigned N_FLAG = 4;

    localparam logic [ADDR_W-1:0] REG_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] REG_LO   = 3'd1;
    localparam logic [ADDR_W-1:0] REG_HI   = 3'd2;
    localparam logic [ADDR_W-1:0] REG_MASK = 3'd3;
    localparam logic [ADDR_W-1:0] REG_FLAG = 3'd4;

    // count bit that feeds each flag, flag 0 first: 32, 8, 2, 1 Hz
    localparam int unsigned FLAG_STAGE [N_FLAG] = '{2, 4, 6, 7};

    typedef enum logic {
        RUN_OFF,
        RUN_ON
    } run_state_t;

    typedef enum logic {
        SNAP_IDLE,
        SNAP_HELD
    } snap_state_t;

endpackage

// File: rtl/ctmr_counter.sv
module ctmr_counter
    import ctmr_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ctrl_wr,
    input  logic         run_bit,
    input  logic         clear_bit,
    output logic [W-1:0] count,
    output logic         running,
    output logic [W-1:0] stage_fall
);

    run_state_t state_q, state_d;
    logic       step;
    logic       clear;
    logic [W-1:0] count_inc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_OFF;
        else        state_q <= state_d;
    end

    // transitions: START and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_OFF: if (ctrl_wr && run_bit)  state_d = RUN_ON;
            RUN_ON:  if (ctrl_wr && !run_bit) state_d = RUN_OFF;
            default: state_d = RUN_OFF;
        endcase
    end

    // outputs of the run machine
    always_comb begin
        running   = (state_q == RUN_ON);
        clear     = ctrl_wr && clear_bit;
        step      = running && tick;
        count_inc = count + W'(1);
        stage_fall = (step && !clear) ? (count & ~count_inc) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (step)  count <= count_inc;
    end

endmodule

// File: rtl/ctmr_hold.sv
module ctmr_hold
    import ctmr_pkg::*;
#(
    parameter int unsigned DW         = NIB_W,
    parameter int unsigned HOLD_TICKS = 2,
    localparam int unsigned TW        = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_lo,
    input  logic          rd_hi,
    input  logic          slow_tick,
    input  logic [DW-1:0] live_hi,
    output logic [DW-1:0] hi_view,
    output logic          held
);

    snap_state_t state_q, state_d;
    logic [DW-1:0] snap_q;
    logic [TW-1:0] tcnt_q;
    logic          expire;
    logic          take;

    always_comb begin
        expire = slow_tick && (tcnt_q == TW'(HOLD_TICKS - 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNAP_IDLE;
        else        state_q <= state_d;
    end

    // transitions: CAPTURE, RECAPTURE, CONSUME, EXPIRE
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            SNAP_IDLE: begin
                if (rd_lo) begin
                    state_d = SNAP_HELD;
                    take    = 1'b1;
                end
            end
            SNAP_HELD: begin
                if (rd_lo) begin
                    take = 1'b1;
                end else if (rd_hi || expire) begin
                    state_d = SNAP_IDLE;
                end
            end
            default: state_d = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            tcnt_q <= '0;
        end else if (take) begin
            snap_q <= live_hi;
            tcnt_q <= '0;
        end else if (state_q == SNAP_HELD && slow_tick && !expire) begin
            tcnt_q <= tcnt_q + TW'(1);
        end
    end

    // outputs
    always_comb begin
        held    = (state_q == SNAP_HELD);
        hi_view = held ? snap_q : live_hi;
    end

endmodule

// File: rtl/ctmr_irq.sv
module ctmr_irq
    import ctmr_pkg::*;
#(
    parameter int unsigned NF = N_FLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_vec,
    input  logic          mask_wr,
    input  logic          flag_wr,
    input  logic [NF-1:0] wdata,
    output logic [NF-1:0] flags,
    output logic [NF-1:0] mask,
    output logic          irq
);

    logic [NF-1:0] clr_vec;

    always_comb clr_vec = flag_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            mask  <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
            if (mask_wr) mask <= wdata;
        end
    end

    always_comb irq = |(flags & mask);

endmodule

// File: rtl/rtc_clock_timer.sv
module rtc_clock_timer
    import ctmr_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_256,
    input  logic              tick_hold,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [NIB_W-1:0]  wdata,
    output logic [NIB_W-1:0]  rdata,
    output logic              irq
);

    logic wr_ctrl, wr_mask, wr_flag, rd_lo, rd_hi;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  stage_fall;
    logic              running;
    logic [NIB_W-1:0]  hi_view;
    logic              held;
    logic [N_FLAG-1:0] set_vec, flags, mask;

    always_comb begin
        wr_ctrl = wr_en && (addr == REG_CTRL);
        wr_mask = wr_en && (addr == REG_MASK);
        wr_flag = wr_en && (addr == REG_FLAG);
        rd_lo   = rd_en && (addr == REG_LO);
        rd_hi   = rd_en && (addr == REG_HI);
    end

    ctmr_counter #(.W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_256),
        .ctrl_wr    (wr_ctrl),
        .run_bit    (wdata[0]),
        .clear_bit  (wdata[1]),
        .count      (count),
        .running    (running),
        .stage_fall (stage_fall)
    );

    ctmr_hold #(.DW(NIB_W), .HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .slow_tick (tick_hold),
        .live_hi   (count[CNT_W-1:NIB_W]),
        .hi_view   (hi_view),
        .held      (held)
    );

    for (genvar g = 0; g < N_FLAG; g++) begin : g_flag_src
        assign set_vec[g] = stage_fall[FLAG_STAGE[g]];
    end

    ctmr_irq #(.NF(N_FLAG)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .mask_wr (wr_mask),
        .flag_wr (wr_flag),
        .wdata   (wdata),
        .flags   (flags),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: rdata = {3'b000, running};
            REG_LO:   rdata = count[NIB_W-1:0];
            REG_HI:   rdata = hi_view;
            REG_MASK: rdata = mask;
            REG_FLAG: rdata = flags;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk
    import ctmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [NIB_W-1:0]  wdata,
    input logic [NIB_W-1:0]  rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic              running,
    input logic              held,
    input logic [NIB_W-1:0]  hi_view,
    input logic [N_FLAG-1:0] set_vec,
    input logic [N_FLAG-1:0] flags,
    input logic [N_FLAG-1:0] mask
);

    // R1
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_CTRL) |-> (rdata[3:1] == 3'b000));

    // R2
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL && wdata[1]) |=> (count == '0));

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(wr_en && addr == REG_CTRL)) |=> $stable(count));

    // R6
    snapshot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !(rd_en && addr == REG_LO)) |=> (!held || $stable(hi_view)));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_FLAG && set_vec == '0) |=> ((flags & $past(wdata)) == '0));

    // R10
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

bind rtc_clock_timer ctmr_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .count   (count),
    .running (running),
    .held    (held),
    .hi_view (hi_view),
    .set_vec (set_vec),
    .flags   (flags),
    .mask    (mask)
);

// File: tb/test_rtc_clock_timer.sv
module test_rtc_clock_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_256 = 1'b0;
    logic       tick_hold = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic       irq;

    always #2 clk = ~clk;

    rtc_clock_timer #(.HOLD_TICKS(2)) i_rtc_clock_timer (
        .clk(clk), .rst_n(rst_n), .tick_256(tick_256), .tick_hold(tick_hold),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // requirement model
    logic [7:0] m_cnt = '0;
    bit         m_run = 0;
    logic [3:0] m_flags = '0;
    logic [3:0] m_mask = '0;
    bit         m_held = 0;
    logic [3:0] m_snap = '0;
    int         m_tcnt = 0;

    function automatic logic [3:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {3'b000, m_run};
            3'd1: return m_cnt[3:0];
            3'd2: return m_held ? m_snap : m_cnt[7:4];
            3'd3: return m_mask;
            3'd4: return m_flags;
            default: return 4'h0;
        endcase
    endfunction

    function automatic void model_tick();
        logic [7:0] nx;
        logic [7:0] fell;
        if (m_run) begin
            nx = m_cnt + 8'd1;
            fell = m_cnt & ~nx;
            m_flags = m_flags | {fell[7], fell[6], fell[4], fell[2]};
            m_cnt = nx;
        end
    endfunction

    function automatic void model_write(input logic [2:0] a, input logic [3:0] d);
        case (a)
            3'd0: begin
                if (d[1]) m_cnt = '0;
                m_run = d[0];
            end
            3'd3: m_mask = d;
            3'd4: m_flags = m_flags & ~d;
            default: ;
        endcase
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [3:0] d, input bit with_tick);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1; tick_256 = with_tick;
        @(posedge clk); #1;
        wr_en = 1'b0; tick_256 = 1'b0;
        model_write(a, d);
        if (with_tick) model_tick();
    endtask

    task automatic bus_read(input logic [2:0] a, input string tag);
        item_t it;
        @(posedge clk); #1;
        addr = a; rd_en = 1'b1;
        it.exp = model_read(a);
        it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        rd_en = 1'b0;
        if (a == 3'd1) begin
            m_held = 1; m_snap = m_cnt[7:4]; m_tcnt = 0;
        end else if (a == 3'd2) begin
            m_held = 0;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick_256 = 1'b1;
            @(posedge clk); #1; tick_256 = 1'b0;
            model_tick();
        end
    endtask

    task automatic hold_pulse();
        @(posedge clk); #1; tick_hold = 1'b1;
        @(posedge clk); #1; tick_hold = 1'b0;
        if (m_held) begin
            m_tcnt++;
            if (m_tcnt == 2) m_held = 0;
        end
    endtask

    task automatic check_irq(input string tag);
        logic e;
        @(negedge clk);
        e = |(m_flags & m_mask);
        n_run++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            n_run++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty actual=%h expected=none", rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, addr, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 5; a++) bus_read(3'(a), "R11");
        check_irq("R11");
        // R1 unused addresses
        bus_read(3'd5, "R1");
        bus_read(3'd7, "R1");

        // R4 ticks ignored while stopped, then start
        ticks(2);
        bus_read(3'd1, "R4");
        bus_write(3'd0, 4'b0001, 0);
        bus_read(3'd0, "R1");
        ticks(5);
        bus_read(3'd1, "R4");
        bus_read(3'd2, "R5");

        // R5 writes to data nibbles ignored
        bus_write(3'd1, 4'hF, 0);
        bus_write(3'd2, 4'hF, 0);
        bus_read(3'd1, "R5");
        bus_read(3'd2, "R5");

        // R4 stop holds, resume continues
        bus_write(3'd0, 4'b0000, 0);
        ticks(3);
        bus_read(3'd1, "R4");

        // R3 clear while stopped stays at zero; clear bit reads 0 (R1)
        bus_write(3'd0, 4'b0010, 0);
        ticks(2);
        bus_read(3'd1, "R3");
        bus_read(3'd0, "R1");

        // R8 32 Hz flag on fall of bit 2
        bus_write(3'd0, 4'b0001, 0);
        ticks(8);
        bus_read(3'd1, "R4");
        bus_read(3'd4, "R8");
        check_irq("R10");

        // R10 enable and irq
        bus_write(3'd3, 4'b0001, 0);
        bus_read(3'd3, "R10");
        check_irq("R10");
        // R9 write 0 no effect, write 1 clears
        bus_write(3'd4, 4'b0000, 0);
        bus_read(3'd4, "R9");
        bus_write(3'd4, 4'b0001, 0);
        bus_read(3'd4, "R9");
        check_irq("R10");

        // R2 clear while running continues from zero
        ticks(3);
        bus_write(3'd0, 4'b0011, 0);
        bus_read(3'd1, "R2");
        ticks(1);
        bus_read(3'd1, "R2");

        // R6 capture, count moves, held value returned, then released
        ticks(30);
        bus_read(3'd1, "R6");
        ticks(1);
        bus_read(3'd2, "R6");
        bus_read(3'd2, "R6");
        bus_read(3'd4, "R8");

        // R7 one timeout pulse keeps the copy
        hold_pulse();
        bus_read(3'd1, "R7");
        ticks(16);
        hold_pulse();
        bus_read(3'd2, "R7");
        // R7 two timeout pulses release it
        bus_read(3'd1, "R7");
        ticks(16);
        hold_pulse();
        hold_pulse();
        bus_read(3'd2, "R7");
        // R6 recapture
        bus_read(3'd1, "R6");
        ticks(16);
        bus_read(3'd1, "R6");
        ticks(16);
        bus_read(3'd2, "R6");

        // R9 set wins over a same-cycle clear
        bus_write(3'd4, 4'hF, 0);
        ticks(8);
        while (m_cnt[2:0] != 3'b111) ticks(1);
        bus_write(3'd4, 4'b0001, 1);
        bus_read(3'd4, "R9");

        // R5 R8 wrap sets every flag
        while (m_cnt != 8'hFF) ticks(1);
        bus_write(3'd4, 4'hF, 0);
        bus_write(3'd3, 4'hF, 0);
        check_irq("R10");
        ticks(1);
        bus_read(3'd4, "R8");
        bus_read(3'd1, "R5");
        bus_read(3'd2, "R5");
        check_irq("R10");

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule